// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address front end of a synchronous burst cache memory built from 32-bit words. On a clock edge where an address strobe is accepted it captures a 17-bit word address, together with the burst order and the three chip-enable inputs. It then presents the full address to the memory array. The upper 15 bits stay fixed, and the low two bits step through a four-beat burst that wraps inside its aligned group of four words.

There are two strobes. One comes from the processor, and it is accepted only while the first chip enable is active. The other comes from the cache controller, and it is always accepted. The burst moves on by one beat only on edges where the advance input is high. A strap input chosen at load time selects either interleaved order (start XOR beat) or linear order (start plus beat, modulo 4).

A small state machine carries the burst position and the selected state. Its states are ST_IDLE (deselected, beat 0), ST_B0, ST_B1, ST_B2 and ST_B3. The transitions are:
- load_sel: any state moves to ST_B0 when the load samples all enables active.
- load_desel: any state moves to ST_IDLE when the load samples any enable inactive.
- step: each of ST_B0 to ST_B3 moves to the next beat on advance without a load.
- wrap: ST_B3 moves back to ST_B0 on advance.
- hold: without a load or an advance the state stays where it is. ST_IDLE also stays put on advance.

Top module: `burst_addr_seq`

## Requirements
- R1: A load happens on a rising edge when `strb_ctl`=1, or when `strb_cpu`=1 and `en_a`=1. When both strobes are high it counts as one load. `strb_cpu` with `en_a`=0 and `strb_ctl`=0 is ignored. After a load, `mem_addr` equals the captured `addr_in`.
- R2: A load takes priority over `adv` on the same edge, and every load restarts the burst at beat 0, so `mem_addr[1:0]` equals the captured low bits.
- R3: Without a load, the burst position moves forward one beat only on an edge with `adv`=1. Otherwise `mem_addr` and `mem_sel` hold their values.
- R4: When `ord_ilv`=1 at load, beat b (0..3) presents low bits equal to start XOR b. The order stays fixed until the next load, even if `ord_ilv` changes.
- R5: When `ord_ilv`=0 at load, beat b presents low bits equal to (start + b) mod 4.
- R6: During a burst, `mem_addr[16:2]` never changes. After four advances the low bits are back at the start value.
- R7: `mem_sel` equals `en_a & en_b & ~en_c_n` as sampled on the last load edge. It holds, whatever the enables do, until the next load.
- R8: A synchronous reset (`rst`=1 on a rising edge) forces `mem_addr`=0 and `mem_sel`=0.
- R9: While deselected (`mem_sel`=0), `adv` has no effect on `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 17 | Word address captured on a load |
| strb_cpu | input | 1 | Processor address strobe, active high, gated by en_a |
| strb_ctl | input | 1 | Controller address strobe, active high, ungated |
| adv | input | 1 | Advance burst by one beat |
| ord_ilv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| en_a | input | 1 | Chip enable A, active high |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| mem_addr | output | 17 | Current word address to the array |
| mem_sel | output | 1 | Array selected for this burst |

## Verification
Every result is due on the first rising edge after its stimulus. That covers the captured address after a load, the next beat after an advance, the held value after a stall and the zeroed outputs after reset. The path is a single register stage followed by combinational order logic. The bench therefore applies each input set, waits for that one edge, and samples 1 ns later, before the next set is driven. The sweep covers both orders, all four start offsets, stalls between beats and the full wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_B0   = 3'd1,
        ST_B1   = 3'd2,
        ST_B2   = 3'd3,
        ST_B3   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_sel,
    input  logic              adv,
    output logic [BEAT_W-1:0] beat,
    output logic              sel
);

    seq_state_e st_q;
    seq_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: load beats advance
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = load_sel ? ST_B0 : ST_IDLE;       // load_sel / load_desel
        end else if (adv) begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;             // hold while deselected
                ST_B0:   st_d = ST_B1;               // step
                ST_B1:   st_d = ST_B2;
                ST_B2:   st_d = ST_B3;
                ST_B3:   st_d = ST_B0;               // wrap
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        beat = '0;
        sel  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin beat = 2'd0; sel = 1'b0; end
            ST_B0:   begin beat = 2'd0; sel = 1'b1; end
            ST_B1:   begin beat = 2'd1; sel = 1'b1; end
            ST_B2:   begin beat = 2'd2; sel = 1'b1; end
            ST_B3:   begin beat = 2'd3; sel = 1'b1; end
            default: begin beat = 2'd0; sel = 1'b0; end
        endcase
    end

endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
    parameter int ADDR_W = 17,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ord_in,
    output logic [ADDR_W-LOW_W-1:0] hi_q,
    output logic [LOW_W-1:0]  base_q,
    output logic              ord_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            base_q <= '0;
            ord_q  <= 1'b0;
        end else if (load) begin
            hi_q   <= addr_in[ADDR_W-1:LOW_W];
            base_q <= addr_in[LOW_W-1:0];
            ord_q  <= ord_in;
        end
    end

endmodule

// File: rtl/order_gen.sv
module order_gen #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] base,
    input  logic [LOW_W-1:0] beat,
    input  logic             ilv,
    output logic [LOW_W-1:0] low
);

    logic [LOW_W-1:0] low_x;
    logic [LOW_W-1:0] low_l;

    assign low_x = base ^ beat;       // interleaved
    assign low_l = base + beat;       // linear, wraps modulo 2**LOW_W
    assign low   = ilv ? low_x : low_l;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_cpu,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic              ord_ilv,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              en_c_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic              load_sel;
    logic [BEAT_W-1:0] beat;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] base_q;
    logic              ord_q;
    logic [BEAT_W-1:0] low;

    assign load     = strb_ctl | (strb_cpu & en_a);
    assign load_sel = en_a & en_b & ~en_c_n;

    burst_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_sel (load_sel),
        .adv      (adv),
        .beat     (beat),
        .sel      (mem_sel)
    );

    addr_capture #(.ADDR_W(ADDR_W), .LOW_W(BEAT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .addr_in (addr_in),
        .ord_in  (ord_ilv),
        .hi_q    (hi_q),
        .base_q  (base_q),
        .ord_q   (ord_q)
    );

    order_gen #(.LOW_W(BEAT_W)) u_ord (
        .base (base_q),
        .beat (beat),
        .ilv  (ord_q),
        .low  (low)
    );

    assign mem_addr = {hi_q, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strb_cpu,
    input logic              strb_ctl,
    input logic              adv,
    input logic              en_a,
    input logic              en_b,
    input logic              en_c_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel
);

    logic ld;
    assign ld = strb_ctl | (strb_cpu & en_a);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (mem_sel == 1'b0 && mem_addr == '0));

    assert_load_captures_R1: assert property (@(posedge clk) disable iff (rst)
        ld |=> mem_addr == $past(addr_in));

    assert_load_enables_R7: assert property (@(posedge clk) disable iff (rst)
        ld |=> mem_sel == $past(en_a & en_b & ~en_c_n));

    assert_stall_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv) |=> ($stable(mem_addr) && $stable(mem_sel)));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(mem_addr[ADDR_W-1:2]));

    assert_advance_moves_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv && mem_sel) |=> mem_addr[1:0] != $past(mem_addr[1:0]));

    assert_desel_ignores_adv_R9: assert property (@(posedge clk) disable iff (rst)
        (!ld && !mem_sel) |=> ($stable(mem_addr) && !mem_sel));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_in  (addr_in),
    .strb_cpu (strb_cpu),
    .strb_ctl (strb_ctl),
    .adv      (adv),
    .en_a     (en_a),
    .en_b     (en_b),
    .en_c_n   (en_c_n),
    .mem_addr (mem_addr),
    .mem_sel  (mem_sel)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [16:0] addr_in;
    logic        strb_cpu, strb_ctl, adv, ord_ilv, en_a, en_b, en_c_n;
    logic [16:0] mem_addr;
    logic        mem_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    burst_addr_seq u_burst_addr_seq (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .adv(adv), .ord_ilv(ord_ilv),
        .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n),
        .mem_addr(mem_addr), .mem_sel(mem_sel)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        strb_cpu = 0; strb_ctl = 0; adv = 0;
    endtask

    function automatic logic [1:0] exp_low(input logic ilv, input logic [1:0] s, input int b);
        logic [1:0] bb;
        bb = 2'(b % 4);
        return ilv ? (s ^ bb) : 2'(s + bb);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [16:0] a;
        rst = 1; idle_in(); addr_in = 17'h1ABCD; ord_ilv = 0;
        en_a = 1; en_b = 1; en_c_n = 0;
        strb_ctl = 1;
        tick(); tick();
        chk("R8 sel", {16'd0, mem_sel}, 17'd0);
        chk("R8 addr", mem_addr, 17'd0);
        rst = 0; idle_in();

        // R4 R5 R6 sweep: both orders, all start offsets, stalls between beats
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 3; k++) begin
                    a = {15'(17'h0A5A5 ^ (k * 15'h1357) ^ (s << 4)), 2'(s)};
                    addr_in = a; ord_ilv = m[0];
                    if (k == 0) strb_ctl = 1;
                    else if (k == 1) strb_cpu = 1;
                    else begin strb_cpu = 1; strb_ctl = 1; end
                    tick();
                    idle_in(); addr_in = ~a; ord_ilv = ~m[0];
                    chk("R1 load addr", mem_addr, a);
                    chk("R7 sel after load", {16'd0, mem_sel}, 17'd1);
                    for (int b = 1; b <= 4; b++) begin
                        adv = 0; tick();
                        chk("R3 stall hold", mem_addr, {a[16:2], exp_low(m[0], 2'(s), b - 1)});
                        adv = 1; tick();
                        chk(m[0] ? "R4 interleaved beat" : "R5 linear beat",
                            mem_addr, {a[16:2], exp_low(m[0], 2'(s), b)});
                    end
                    chk("R6 wrap to start", {15'd0, mem_addr[1:0]}, {15'd0, 2'(s)});
                    adv = 0;
                end
            end
        end

        // R2: load with adv on same edge, mid-burst reload restarts at beat 0
        addr_in = 17'h00006; ord_ilv = 0; strb_ctl = 1; adv = 1; tick();
        chk("R2 load over adv", mem_addr, 17'h00006);
        strb_ctl = 0; adv = 1; tick();
        chk("R2 step", mem_addr, 17'h00007);
        addr_in = 17'h10001; strb_ctl = 1; adv = 1; tick();
        chk("R2 reload beat0", mem_addr, 17'h10001);
        idle_in();

        // R1: processor strobe ignored with en_a low
        en_a = 0; addr_in = 17'h0FFFF; strb_cpu = 1; tick();
        chk("R1 cpu strobe ignored addr", mem_addr, 17'h10001);
        chk("R1 cpu strobe ignored sel", {16'd0, mem_sel}, 17'd1);
        // R1/R7: controller strobe loads regardless of en_a; deselects
        strb_cpu = 0; strb_ctl = 1; addr_in = 17'h02222; tick();
        chk("R1 ctl loads with en_a low", mem_addr, 17'h02222);
        chk("R7 desel en_a", {16'd0, mem_sel}, 17'd0);
        idle_in();
        // R9: adv ignored while deselected
        adv = 1; tick(); tick();
        chk("R9 adv ignored", mem_addr, 17'h02222);
        chk("R9 stays desel", {16'd0, mem_sel}, 17'd0);
        idle_in();
        // R7: en_b low and en_c_n high deselect
        en_a = 1; en_b = 0; strb_ctl = 1; addr_in = 17'h00100; tick();
        chk("R7 desel en_b", {16'd0, mem_sel}, 17'd0);
        en_b = 1; en_c_n = 1; tick();
        chk("R7 desel en_c_n", {16'd0, mem_sel}, 17'd0);
        en_c_n = 0; tick();
        chk("R7 select", {16'd0, mem_sel}, 17'd1);
        idle_in();
        // R7: enables changing without load do not affect sel
        en_b = 0; en_c_n = 1; adv = 1; tick();
        chk("R7 held sel", {16'd0, mem_sel}, 17'd1);
        chk("R5 step with held sel", mem_addr, 17'h00101);
        idle_in(); en_b = 1; en_c_n = 0;
        // R4: order fixed at load even if strap changes mid-burst
        addr_in = 17'h00001; ord_ilv = 1; strb_ctl = 1; tick();
        strb_ctl = 0; ord_ilv = 0; adv = 1; tick();
        chk("R4 order latched b1", mem_addr, 17'h00000);
        tick();
        chk("R4 order latched b2", mem_addr, 17'h00003);
        idle_in();
        // R8: reset mid-burst
        rst = 1; tick();
        chk("R8 mid reset addr", mem_addr, 17'd0);
        chk("R8 mid reset sel", {16'd0, mem_sel}, 17'd0);
        rst = 0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule